// File: doc/BRIEF.md
# Watchdog Timer with Guarded Control Register

This block is a watchdog timer. A slow oscillator tick advances a timeout counter, and software must pulse a clear input often enough to keep the counter from reaching its limit. If the counter reaches the limit while the watchdog is on, the block drives a reset request for one system clock. A 3-bit prescale select picks one of eight limits, each twice the one below it. With the default base, the limits run from 16384 to 2097152 ticks.

Software reaches the block through one 8-bit register with a write strobe, write data and read data. Turning the watchdog on is always allowed. Turning it off, or changing its timeout, is guarded. An unlock write opens a window of four system clocks, and the new values are accepted only if they are written inside that window. A strap input selects a protected mode. In that mode the watchdog cannot be turned off at all, and the guarded path can only change the timeout.

The oscillator tick comes in as a one-cycle enable that is already synchronous to the system clock. The reset input is asynchronous and active low, and its release is synchronised inside the block.

Top module: `wdt_guarded`

## Requirements
- R1: After reset, with the strap low, the read data is 0x00 and the reset output stays low.
- R2: With the strap low, a write with bit 4 = 0 and bit 3 = 1 turns the watchdog on at once, and read bit 3 becomes 1.
- R3: A write with bit 4 = 1 and bit 3 = 1 is an unlock. Read bit 4 is 1 from the next cycle. It returns to 0 by itself after four cycles, so writes presented in any of the four cycles that follow the unlock write find the window open.
- R4: While the window is open, a write with bit 4 = 0 loads bits 2:0 as the new prescale select. In unprotected mode the same write also loads bit 3 as the new enable. The write closes the window.
- R5: While the window is closed, a write can neither clear bit 3 nor change bits 2:0.
- R6: A write with bit 4 = 1 and bit 3 = 0 changes nothing in the register and opens no window.
- R7: With the strap high, read bit 3 is always 1 and the watchdog always runs. The value written to bit 3 is ignored, but the prescale select can still be changed through the unlock window.
- R8: With prescale select p, the reset pulse is produced on the (2^(BASE_SHIFT+p))-th oscillator tick counted from a clear.
- R9: The reset output is high for exactly one cycle. Counting then restarts from zero, so the next pulse follows after one more full period.
- R10: A clear pulse sets the tick count to zero, and it overrides a tick that arrives in the same cycle. An accepted change of the prescale select also sets the count to zero.
- R11: While the watchdog is off, the reset output never rises and the count is held at zero.
- R12: Read bits 7:5 are always zero, whatever was written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data: bit 4 change window, bit 3 enable, bits 2:0 prescale |
| wd_clear | input | 1 | Restart the timeout count |
| safe_strap | input | 1 | High selects the protected mode |
| osc_tick | input | 1 | One-cycle watchdog oscillator tick, synchronous to clk |
| wd_reset | output | 1 | One-cycle watchdog reset request |

## Verification
The bench goes after the edges of the window. A change presented on the fourth cycle after the unlock must be taken, and one on the fifth must be refused. A design whose window is off by one would either take a late change or lose a legal one. For each of the eight prescale settings and two tick rates, the bench measures the exact cycle in which the pulse appears. A wrong mapping, or a compare one tick early or late, shifts that cycle. The bench also checks that a clear wins over a tick arriving in the same cycle, that a clear write or a prescale write outside the window is refused, that a half-formed unlock opens no window, and that the strap keeps the watchdog running whatever is written to the enable bit.

// File: rtl/wdtg_pkg.sv
package wdtg_pkg;
  localparam int unsigned WIN_BIT = 4;
  localparam int unsigned ENA_BIT = 3;
  localparam int unsigned PSEL_W  = 3;
  localparam int unsigned NSEL    = 1 << PSEL_W;

  typedef struct packed {
    logic              win;
    logic              ena;
    logic [PSEL_W-1:0] psel;
  } wdtg_ctl_t;
endpackage

// File: rtl/wdtg_rst_sync.sv
module wdtg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/wdtg_ctrl.sv
module wdtg_ctrl
  import wdtg_pkg::*;
#(
  parameter int unsigned WIN_CYCLES = 4,
  localparam int unsigned WIN_W = $clog2(WIN_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [4:0]       reg_wdata,
  input  logic             safe_strap,
  output wdtg_ctl_t        ctl,
  output logic             psel_chg
);
  logic              win_q, win_n;
  logic [WIN_W-1:0]  age_q, age_n;
  logic              ena_q, ena_n;
  logic [PSEL_W-1:0] psel_q, psel_n;
  logic              w_win, w_ena, unlock;
  logic [PSEL_W-1:0] w_psel;

  assign w_win  = reg_wdata[WIN_BIT];
  assign w_ena  = reg_wdata[ENA_BIT];
  assign w_psel = reg_wdata[PSEL_W-1:0];
  assign unlock = reg_wr && w_win && w_ena;

  always_comb begin
    win_n    = win_q;
    age_n    = age_q;
    ena_n    = ena_q;
    psel_n   = psel_q;
    psel_chg = 1'b0;
    // the window ages one step per cycle and closes on its last step
    if (win_q) begin
      if (age_q == WIN_W'(1)) win_n = 1'b0;
      else                    age_n = age_q - WIN_W'(1);
    end
    if (unlock) begin
      win_n = 1'b1;
      age_n = WIN_W'(WIN_CYCLES);
      if (!safe_strap) ena_n = 1'b1;
    end else if (reg_wr && !w_win) begin
      if (win_q) begin
        if (!safe_strap) ena_n = w_ena;
        psel_n   = w_psel;
        psel_chg = (w_psel != psel_q);
        win_n    = 1'b0;
      end else if (w_ena && !safe_strap) begin
        ena_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= 1'b0;
      age_q  <= '0;
      ena_q  <= 1'b0;
      psel_q <= '0;
    end else begin
      win_q <= win_n;
      if (win_q || unlock) age_q <= age_n;
      if (reg_wr) begin
        ena_q  <= ena_n;
        psel_q <= psel_n;
      end
    end
  end

  assign ctl.win  = win_q;
  assign ctl.ena  = ena_q || safe_strap;
  assign ctl.psel = psel_q;
endmodule

// File: rtl/wdtg_counter.sv
module wdtg_counter
  import wdtg_pkg::*;
#(
  parameter int unsigned BASE_SHIFT = 14,
  localparam int unsigned CNT_W = BASE_SHIFT + NSEL - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              ena,
  input  logic              restart,
  input  logic [PSEL_W-1:0] psel,
  output logic              wd_reset
);
  logic [CNT_W-1:0] term [NSEL];
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             fire, cnt_ld, pulse_q;

  for (genvar g = 0; g < NSEL; g++) begin : g_term
    assign term[g] = CNT_W'((64'd1 << (BASE_SHIFT + g)) - 64'd1);
  end

  always_comb begin
    cnt_n = cnt_q;
    fire  = 1'b0;
    if (!ena || restart) begin
      cnt_n = '0;
    end else if (tick) begin
      if (cnt_q == term[psel]) begin
        cnt_n = '0;
        fire  = 1'b1;
      end else begin
        cnt_n = cnt_q + CNT_W'(1);
      end
    end
  end

  assign cnt_ld = !ena || restart || tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= fire;
      if (cnt_ld) cnt_q <= cnt_n;
    end
  end

  assign wd_reset = pulse_q;
endmodule

// File: rtl/wdt_guarded.sv
module wdt_guarded
  import wdtg_pkg::*;
#(
  parameter int unsigned BASE_SHIFT = 14,
  parameter int unsigned WIN_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       wd_clear,
  input  logic       safe_strap,
  input  logic       osc_tick,
  output logic       wd_reset
);
  logic      rst_n_s;
  wdtg_ctl_t ctl;
  logic      psel_chg;
  logic      unused_hi;

  assign unused_hi = ^reg_wdata[7:5];

  wdtg_rst_sync #(.STAGES(2)) u_rsync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  wdtg_ctrl #(.WIN_CYCLES(WIN_CYCLES)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata[4:0]),
    .safe_strap (safe_strap),
    .ctl        (ctl),
    .psel_chg   (psel_chg)
  );

  wdtg_counter #(.BASE_SHIFT(BASE_SHIFT)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .tick     (osc_tick),
    .ena      (ctl.ena),
    .restart  (wd_clear || psel_chg),
    .psel     (ctl.psel),
    .wd_reset (wd_reset)
  );

  assign reg_rdata = {3'b000, ctl.win, ctl.ena, ctl.psel};
endmodule

// File: rtl/wdt_guarded_chk.sv
module wdt_guarded_chk #(
  parameter int unsigned WIN_CYCLES = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       wd_clear,
  input logic       safe_strap,
  input logic       wd_reset
);
  logic [7:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                       run_q <= '0;
    else if (reg_wr && reg_wdata[4] && reg_wdata[3])  run_q <= '0;
    else if (reg_rdata[4])                            run_q <= run_q + 8'd1;
    else                                              run_q <= '0;
  end

  assert_window_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= 8'(WIN_CYCLES));

  assert_locked_psel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_rdata[4]) |=> (reg_rdata[2:0] == $past(reg_rdata[2:0])));

  assert_locked_ena_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_rdata[4] && reg_rdata[3]) |=> reg_rdata[3]);

  assert_strap_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
    safe_strap |-> reg_rdata[3]);

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wd_reset |=> !wd_reset);

  assert_clear_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wd_clear |=> !wd_reset);

  assert_off_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[3] |=> !wd_reset);

  assert_upper_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[7:5] == 3'b000);
endmodule

bind wdt_guarded wdt_guarded_chk #(.WIN_CYCLES(WIN_CYCLES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr     (reg_wr),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .wd_clear   (wd_clear),
  .safe_strap (safe_strap),
  .wd_reset   (wd_reset)
);

// File: tb/test_wdt_guarded.sv
`timescale 1ns/1ps
module test_wdt_guarded;
  localparam int unsigned BASE = 2;
  localparam int unsigned WIN  = 4;

  logic       clk;
  logic       rst_n;
  logic       reg_wr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       wd_clear;
  logic       safe_strap;
  logic       osc_tick;
  logic       wd_reset;
  int         total;
  int         bad;
  bit         done;

  wdt_guarded #(.BASE_SHIFT(BASE), .WIN_CYCLES(WIN)) i_wdt_guarded (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .wd_clear   (wd_clear),
    .safe_strap (safe_strap),
    .osc_tick   (osc_tick),
    .wd_reset   (wd_reset)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    reg_wr = 1'b1;
    reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    reg_wdata = 8'h00;
  endtask

  task automatic do_reset(input logic strap);
    rst_n = 1'b0;
    safe_strap = strap;
    idle(3);
    rst_n = 1'b1;
    idle(4);
  endtask

  // clear, then tick every div cycles; report the cycles of the first two pulses
  task automatic measure(input int div, input int lim, output int first, output int second);
    int seen = 0;
    first = -1;
    second = -1;
    wd_clear = 1'b1;
    osc_tick = 1'b0;
    @(negedge clk);
    wd_clear = 1'b0;
    for (int c = 0; c < 3 * lim * div + 10 && seen < 2; c++) begin
      osc_tick = (c % div == 0);
      @(negedge clk);
      if (wd_reset) begin
        if (seen == 0) first = c;
        else           second = c;
        seen++;
      end
    end
    osc_tick = 1'b0;
  endtask

  initial begin
    int f, s, lim, pulses;
    total = 0; bad = 0; done = 0;
    reg_wr = 0; reg_wdata = 0; wd_clear = 0; osc_tick = 0; safe_strap = 0; rst_n = 0;
    do_reset(1'b0);
    chk("R1 reset value", reg_rdata, 8'h00);

    // R11: disabled watchdog ignores a long run of ticks
    pulses = 0;
    osc_tick = 1'b1;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (wd_reset) pulses++;
    end
    osc_tick = 1'b0;
    chk("R11 no pulse while off", pulses, 0);
    chk("R1 reset output low", wd_reset, 0);

    wr(8'hE8);
    chk("R2 enable without unlock", reg_rdata[3], 1);
    chk("R12 upper bits zero", reg_rdata, 8'h08);

    wr(8'h00);
    chk("R5 clear refused when closed", reg_rdata, 8'h08);
    wr(8'h0D);
    chk("R5 prescale refused when closed", reg_rdata, 8'h08);
    wr(8'h10);
    chk("R6 half unlock ignored", reg_rdata, 8'h08);
    idle(1);
    chk("R6 no window opened", reg_rdata[4], 0);

    wr(8'h18);
    chk("R3 window opens", reg_rdata, 8'h18);
    idle(3);
    chk("R3 window still open", reg_rdata[4], 1);
    wr(8'h0B);
    chk("R4 change on last window cycle", reg_rdata, 8'h0B);

    wr(8'h18);
    idle(3);
    chk("R3 window open before expiry", reg_rdata[4], 1);
    idle(1);
    chk("R3 window self-closes", reg_rdata, 8'h0B);
    wr(8'h05);
    chk("R5 late change refused", reg_rdata, 8'h0B);

    wr(8'h18);
    wr(8'h00);
    chk("R4 disable inside window", reg_rdata, 8'h00);
    measure(1, 4, f, s);
    chk("R11 no pulse after disable", f, -1);

    // R8/R9 sweep over every prescale at two tick rates
    for (int p = 0; p < 8; p++) begin
      wr(8'h18);
      wr(8'h08 | 8'(p));
      chk("R4 prescale load", reg_rdata, 8'h08 | p);
      lim = 1 << (BASE + p);
      for (int div = 1; div <= 2; div++) begin
        measure(div, lim, f, s);
        chk("R8 timeout cycle", f, (lim - 1) * div);
        chk("R9 restart period", s - f, lim * div);
      end
    end

    // R10: clear wins over a simultaneous tick
    wr(8'h18);
    wr(8'h08);
    wd_clear = 1'b1;
    @(negedge clk);
    wd_clear = 1'b0;
    osc_tick = 1'b1;
    idle(3);
    wd_clear = 1'b1;
    @(negedge clk);
    chk("R10 no pulse on clear cycle", wd_reset, 0);
    wd_clear = 1'b0;
    pulses = -1;
    for (int c = 0; c < 10 && pulses < 0; c++) begin
      @(negedge clk);
      if (wd_reset) pulses = c;
    end
    osc_tick = 1'b0;
    chk("R10 count restarted by clear", pulses, 3);

    // R7: protected mode
    do_reset(1'b1);
    chk("R7 enable reads one", reg_rdata, 8'h08);
    wr(8'h00);
    chk("R7 enable stays on", reg_rdata, 8'h08);
    wr(8'h18);
    wr(8'h02);
    chk("R7 prescale through window", reg_rdata, 8'h0A);
    wr(8'h05);
    chk("R7 prescale locked outside", reg_rdata, 8'h0A);
    measure(1, 16, f, s);
    chk("R7 runs in protected mode", f, 15);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule